// File: doc/BRIEF.md
# Ramp-Timeout Undervoltage Lockout Filter

This block decides whether a switching converter's input supply is high enough to run. It does not measure voltage. Once per switching period it checks whether the feed-forward ramp reached its 90 % mark before the next master clock pulse. The ramp slope follows the input voltage, so a ramp that finishes in time means the line is adequate ("good" period). A ramp that is still climbing when the next pulse arrives means the line is low ("bad" period). An early pulse from an external synchronisation source that cuts the ramp short also gives a bad period.

A small saturating filter counter keeps single spikes and fast line transients from toggling the decision. While locked out, good periods count up and bad periods step the count back. Seven net good periods raise power-good and send a one-cycle soft-start request. While running, the roles swap: seven net bad periods drop power-good. For as long as power-good is low, both gate drivers are held off.

Top module: `uvlo_ramp_filter`

## Requirements
- R1: After reset, power_good is 0, gates_off is 1, softstart_req is 0, and the filter counter is zero.
- R2: A period runs from one osc_tick cycle to the next. It is good only if ramp_done was high in some cycle strictly between the two ticks. A ramp_done that coincides with a tick cycle counts for neither period, so a tick that cuts the ramp short gives a bad period. The first tick after reset only opens a period and gives no verdict.
- R3: While locked out, each good verdict adds one to the counter. Each bad verdict subtracts one, but never takes the counter below zero.
- R4: When a good verdict in lockout brings the counter to seven, power_good goes to 1 and softstart_req is high for exactly one cycle. Both happen in the cycle after the deciding tick.
- R5: gates_off is 1 in every cycle where power_good is 0, and 0 whenever power_good is 1.
- R6: While running, each bad verdict adds one to the counter and each good verdict subtracts one, never below zero. When the count reaches seven, power_good falls and gates_off rises in the cycle after the tick. No softstart_req is issued then.
- R7: The counter is cleared on every change between lockout and running. Each new state therefore needs its own seven net qualifying periods.
- R8: power_good changes only in the cycle right after a cycle in which osc_tick was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle master clock pulse marking a switching period boundary |
| ramp_done | input | 1 | Ramp has reached 90 % of full amplitude |
| power_good | output | 1 | Input supply judged adequate |
| softstart_req | output | 1 | One-cycle request to start a soft-start sequence |
| gates_off | output | 1 | Forces both high-side and low-side gates off |

## Verification
The assertions assume that osc_tick is a single-cycle strobe. They also assume that ramp_done, when it is used, is a short strobe that sits inside a period rather than on a tick cycle, except where a tick is meant to interrupt the ramp. The stimulus builds every period from a one-cycle tick followed by two to nine quiet cycles. It places the ramp strobe in the middle of the period, on the tick cycle, or leaves it out. Directed runs walk through entry, decrement, saturation and exit, and a randomised run of periods is then compared with a behavioural model on every cycle.

// File: rtl/uvlo_filt_pkg.sv
package uvlo_filt_pkg;
    typedef enum logic {
        ST_LOCKOUT = 1'b0,
        ST_RUN     = 1'b1
    } uvf_state_e;

    localparam int unsigned UVF_CNT_W_DEFAULT = 3;
endpackage

// File: rtl/uvf_period_judge.sv
module uvf_period_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic ramp_done,
    output logic verdict_vld,
    output logic verdict_good
);
    typedef struct packed {
        logic armed;
        logic seen;
    } judge_t;

    judge_t j_d, j_q;

    always_comb begin
        j_d          = j_q;
        verdict_vld  = osc_tick & j_q.armed;
        verdict_good = j_q.seen;
        if (osc_tick) begin
            j_d.armed = 1'b1;
            j_d.seen  = 1'b0;
        end else if (ramp_done) begin
            j_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end
endmodule

// File: rtl/uvf_event_filter.sv
module uvf_event_filter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_vld,
    input  logic ev_qual,
    output logic trip
);
    localparam logic [CNT_W-1:0] THRESH = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d  = f_q;
        trip = ev_vld & ev_qual & (f_q.cnt == THRESH - ONE);
        if (trip) begin
            f_d.cnt = '0;
        end else if (ev_vld) begin
            if (ev_qual)            f_d.cnt = f_q.cnt + ONE;
            else if (f_q.cnt != '0) f_d.cnt = f_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/uvlo_ramp_filter.sv
module uvlo_ramp_filter
    import uvlo_filt_pkg::*;
#(
    parameter int unsigned CNT_W = UVF_CNT_W_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic ramp_done,
    output logic power_good,
    output logic softstart_req,
    output logic gates_off
);
    typedef struct packed {
        uvf_state_e st;
        logic       ss;
        logic       goff;
    } ctl_t;

    ctl_t c_d, c_q;
    logic verdict_vld, verdict_good, qual, trip;

    uvf_period_judge u_judge (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_tick     (osc_tick),
        .ramp_done    (ramp_done),
        .verdict_vld  (verdict_vld),
        .verdict_good (verdict_good)
    );

    // qualifying period: good while locked out, bad while running
    assign qual = (c_q.st == ST_RUN) ? ~verdict_good : verdict_good;

    uvf_event_filter #(.CNT_W(CNT_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_vld  (verdict_vld),
        .ev_qual (qual),
        .trip    (trip)
    );

    always_comb begin
        c_d    = c_q;
        c_d.ss = 1'b0;
        if (trip) begin
            if (c_q.st == ST_LOCKOUT) begin
                c_d.st = ST_RUN;
                c_d.ss = 1'b1;
            end else begin
                c_d.st = ST_LOCKOUT;
            end
        end
        c_d.goff = (c_d.st == ST_LOCKOUT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_LOCKOUT, ss: 1'b0, goff: 1'b1};
        else        c_q <= c_d;
    end

    assign power_good    = (c_q.st == ST_RUN);
    assign softstart_req = c_q.ss;
    assign gates_off     = c_q.goff;
endmodule

module uvlo_ramp_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_tick,
    input logic ramp_done,
    input logic power_good,
    input logic softstart_req,
    input logic gates_off
);
    p_ss_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_req |=> !softstart_req);
    p_ss_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_req |-> $rose(power_good));
    p_entry_has_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_good) |-> softstart_req);
    p_gates_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gates_off) |-> softstart_req);
    p_gates_vs_pg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        power_good != gates_off);
    p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_good) |-> !softstart_req);
    p_pg_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(osc_tick) |-> $stable(power_good));
endmodule

bind uvlo_ramp_filter uvlo_ramp_filter_chk u_chk (.*);

// File: tb/tb_uvlo_ramp_filter.sv
module tb_uvlo_ramp_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic ramp_done = 1'b0;
    logic power_good, softstart_req, gates_off;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int ss_seen = 0;

    // behavioural reference
    bit m_armed, m_seen, m_run, m_ss;
    int m_cnt;

    uvlo_ramp_filter dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ramp_done(ramp_done),
        .power_good(power_good), .softstart_req(softstart_req), .gates_off(gates_off)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_armed = 0; m_seen = 0; m_cnt = 0; m_run = 0; m_ss = 0;
        end else begin
            bit nss;
            nss = 0;
            if (osc_tick) begin
                if (m_armed) begin
                    bit q;
                    q = m_run ? !m_seen : m_seen;
                    if (q) begin
                        if (m_cnt == 6) begin m_cnt = 0; m_run = !m_run; nss = m_run; end
                        else m_cnt++;
                    end else if (m_cnt > 0) m_cnt--;
                end
                m_armed = 1; m_seen = 0;
            end else if (ramp_done) m_seen = 1;
            m_ss = nss;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 R6 R8 power_good", power_good, m_run);
            check("R5 gates_off", gates_off, !m_run);
            check("R4 softstart_req", softstart_req, m_ss);
            if (softstart_req) ss_seen++;
        end
    end

    initial begin
        wait (cycles > 100000);
        check("watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // kind 0: no ramp; 1: ramp mid-period; 2: ramp only on tick cycle
    task automatic period(input int kind, input int len);
        @(negedge clk);
        osc_tick = 1'b1;
        ramp_done = (kind == 2);
        @(negedge clk);
        osc_tick = 1'b0;
        ramp_done = 1'b0;
        for (int i = 1; i < len; i++) begin
            ramp_done = (kind == 1) && (i == len / 2);
            @(negedge clk);
        end
        ramp_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 power_good", power_good, 0);
        check("R1 gates_off", gates_off, 1);
        check("R1 softstart_req", softstart_req, 0);
        rst_n = 1'b1;
        // first tick only arms (R2); six good verdicts follow
        for (int k = 0; k < 7; k++) period(1, 8);
        check("R2 R3 six good held", power_good, 0);
        period(2, 8);   // seventh good verdict
        check("R4 entered run", power_good, 1);
        check("R4 one request", ss_seen, 1);
        for (int k = 0; k < 5; k++) period(2, 8);
        period(1, 8);
        period(2, 8);   // good verdict steps back
        check("R6 decrement keeps run", power_good, 1);
        period(2, 8);
        period(2, 8);
        check("R6 exited run", power_good, 0);
        check("R6 gates forced off", gates_off, 1);
        check("R6 no request on exit", ss_seen, 1);
        for (int k = 0; k < 7; k++) period(1, 8);
        check("R7 R3 cleared counter needs seven", power_good, 0);
        period(1, 8);
        check("R7 re-entry", power_good, 1);
        check("R4 second request", ss_seen, 2);
        for (int k = 0; k < 6; k++) period(0, 8);
        check("R7 counter cleared on entry", power_good, 1);
        for (int k = 0; k < 400; k++)
            period($urandom_range(0, 2), $urandom_range(3, 10));
        period(0, 4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule